// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This unit builds a 128-bit result from two 128-bit source vectors. Each of the sixteen result bytes picks any one of the 32 bytes held by the two sources, under an index taken from a 128-bit control vector. The same path covers several uses. It can do a general two-register shuffle. It can copy one source byte into many lanes. It can also run sixteen parallel lookups into a 32-entry byte table spread across both sources.

A merge selector can replace the external control vector with an index pattern built inside the unit. That pattern interleaves elements of the two sources at byte, halfword or word size, taken from either the upper or the lower half of the sources. Operations are accepted with an input valid strobe. The result is registered and appears one cycle later with a matching output valid.

Byte numbering is the same for every vector. Byte 0 is the most significant byte (bits 127:120), and byte k occupies bits 127-8k down to 120-8k.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted and after its release, before any accepted operation, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had on the previous clock edge. The result of an operation accepted on edge n is visible after edge n, with one cycle of latency.
- R3: With merge mode none, a control byte whose low five bits are 0 to 15 places byte 0 to 15 of `src_a` into that result byte position.
- R4: With merge mode none, a control byte whose low five bits are 16 to 31 places byte 0 to 15 of `src_b` (index minus 16) into that result byte position.
- R5: Bits 7:5 of each control byte have no effect on the result.
- R6: Several control bytes may carry the same index, and each of those result bytes then receives the same source byte.
- R7: When `in_valid` is 0 on a clock edge, `result` keeps its previous value whatever the other inputs are.
- R8: Merge mode high (code 1) fills result element 2i with element i of `src_a` and result element 2i+1 with element i of `src_b`, for i from 0 to N/2-1. Here N is 16, 8 or 4 elements for merge size byte (code 0), halfword (code 1) or word (code 2 or 3).
- R9: Merge mode low (code 2) does the same as R8 but takes source elements N/2+i instead of i.
- R10: In merge modes high and low, the `ctrl` input has no effect. Merge mode code 3 behaves as mode none (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept an operation on this edge |
| src_a | input | 128 | First source vector, table entries 0 to 15 |
| src_b | input | 128 | Second source vector, table entries 16 to 31 |
| ctrl | input | 128 | Per-byte index vector, low five bits of each byte used |
| merge_mode | input | 2 | 0 none, 1 high, 2 low, 3 same as none |
| merge_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| out_valid | output | 1 | Result of an accepted operation is present |
| result | output | 128 | Registered permuted vector |

## Verification
The bench targets the boundary between the two sources at index 15 and index 16. A design that decodes the source bit wrongly would return the wrong register there, or mirror bytes because the endianness is reversed. It sets the upper three control bits, so a unit that used them would index out of range or pick different bytes. Each merge size is run in both halves with a nonsense control vector: a swapped half, a wrong element width, or a leaked external index shows up as misplaced bytes. Idle cycles with changing inputs expose a result register that loads without `in_valid`, and a check taken before the capturing edge exposes any extra or missing latency.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int unsigned LANES_DEF = 16;
    localparam int unsigned BYTE_W    = 8;

    typedef enum logic [1:0] {
        MRG_NONE = 2'd0,
        MRG_HIGH = 2'd1,
        MRG_LOW  = 2'd2,
        MRG_ALT  = 2'd3
    } mrg_mode_e;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_WIDE = 2'd3
    } esz_e;

endpackage

// File: rtl/vperm_index_gen.sv
module vperm_index_gen
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    localparam int unsigned VEC_W = LANES * BYTE_W,
    localparam int unsigned IDX_W = $clog2(2 * LANES)
) (
    input  logic [VEC_W-1:0]       ctrl_vec,
    input  logic [1:0]             mode,
    input  logic [1:0]             size,
    output logic [LANES*IDX_W-1:0] idx_vec
);

    logic [1:0] lg_esz;
    logic       merging;

    always_comb begin
        lg_esz  = (size == ESZ_WIDE) ? 2'd2 : size;
        merging = (mode == MRG_HIGH) || (mode == MRG_LOW);
    end

    for (genvar d = 0; d < LANES; d++) begin : g_lane
        always_comb begin
            int unsigned elem;
            int unsigned offs;
            int unsigned half_n;
            int unsigned src_el;
            int unsigned pick;
            elem   = d >> lg_esz;
            offs   = d & ((32'd1 << lg_esz) - 32'd1);
            half_n = LANES >> (lg_esz + 2'd1);
            src_el = ((mode == MRG_LOW) ? half_n : 0) + (elem >> 1);
            pick   = ((elem & 1) * LANES) + (src_el << lg_esz) + offs;
            if (merging) begin
                idx_vec[d*IDX_W +: IDX_W] = IDX_W'(pick);
            end else begin
                idx_vec[d*IDX_W +: IDX_W] = ctrl_vec[VEC_W - BYTE_W*(d+1) +: IDX_W];
            end
        end
    end

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    localparam int unsigned VEC_W = LANES * BYTE_W,
    localparam int unsigned IDX_W = $clog2(2 * LANES),
    localparam int unsigned POOL_W = 2 * VEC_W
) (
    input  logic [VEC_W-1:0]       vec_a,
    input  logic [VEC_W-1:0]       vec_b,
    input  logic [LANES*IDX_W-1:0] idx_vec,
    output logic [VEC_W-1:0]       perm_vec
);

    logic [POOL_W-1:0] pool;

    always_comb pool = {vec_a, vec_b};

    for (genvar d = 0; d < LANES; d++) begin : g_out
        always_comb begin
            int unsigned sel;
            sel = int'(idx_vec[d*IDX_W +: IDX_W]);
            perm_vec[VEC_W - BYTE_W*(d+1) +: BYTE_W] =
                pool[POOL_W - BYTE_W*(sel+1) +: BYTE_W];
        end
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    localparam int unsigned VEC_W = LANES * BYTE_W,
    localparam int unsigned IDX_W = $clog2(2 * LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] ctrl,
    input  logic [1:0]       merge_mode,
    input  logic [1:0]       merge_size,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } stage_t;

    logic [LANES*IDX_W-1:0] idx_vec;
    logic [VEC_W-1:0]       perm_vec;
    stage_t                 stage_d, stage_q;

    vperm_index_gen #(.LANES(LANES)) i_index_gen (
        .ctrl_vec (ctrl),
        .mode     (merge_mode),
        .size     (merge_size),
        .idx_vec  (idx_vec)
    );

    vperm_xbar #(.LANES(LANES)) i_xbar (
        .vec_a    (src_a),
        .vec_b    (src_b),
        .idx_vec  (idx_vec),
        .perm_vec (perm_vec)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.data = perm_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    always_comb begin
        out_valid = stage_q.vld;
        result    = stage_q.data;
    end

    logic plain_mode;
    always_comb plain_mode = (merge_mode == MRG_NONE) || (merge_mode == MRG_ALT);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_lane0_srca_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && plain_mode && ctrl[VEC_W-4 +: 4] == 4'h0 && ctrl[VEC_W-8 +: IDX_W] == '0)
        |=> result[VEC_W-1 -: BYTE_W] == $past(src_a[VEC_W-1 -: BYTE_W]));

    p_lane0_srcb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && plain_mode && ctrl[VEC_W-8 +: IDX_W] == IDX_W'(LANES))
        |=> result[VEC_W-1 -: BYTE_W] == $past(src_b[VEC_W-1 -: BYTE_W]));

    p_mrg_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge_mode == MRG_HIGH)
        |=> result[VEC_W-1 -: BYTE_W] == $past(src_a[VEC_W-1 -: BYTE_W]));

    p_mrg_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge_mode == MRG_LOW)
        |=> result[VEC_W-1 -: BYTE_W] == $past(src_a[VEC_W/2-1 -: BYTE_W]));

endmodule

// File: tb/test_vperm_unit.sv
module test_vperm_unit;

    typedef struct packed {
        logic [1:0]   m;
        logic [1:0]   s;
        logic [127:0] c;
        logic [127:0] e;
    } row_t;

    localparam logic [127:0] SEQ_A = 128'h000102030405060708090A0B0C0D0E0F;
    localparam logic [127:0] SEQ_B = 128'h101112131415161718191A1B1C1D1E1F;
    localparam logic [127:0] JUNK  = 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100;
    localparam int NROWS = 13;

    localparam row_t TBL [NROWS] = '{
        '{2'd0, 2'd0, SEQ_A, SEQ_A},                                          // R3 identity
        '{2'd0, 2'd0, SEQ_B, SEQ_B},                                          // R4 second source
        '{2'd0, 2'd0, 128'h1F1E1D1C1B1A19181716151413121110,
                      128'h1F1E1D1C1B1A19181716151413121110},                 // R4 reversed
        '{2'd0, 2'd0, {16{8'hFF}}, {16{8'h1F}}},                              // R5 top bits set
        '{2'd0, 2'd0, {16{8'h05}}, {16{8'h05}}},                              // R6 replication
        '{2'd1, 2'd0, JUNK, 128'h00100111021203130414051506160717},          // R8 byte
        '{2'd1, 2'd1, JUNK, 128'h00011011020312130405141506071617},          // R8 half
        '{2'd1, 2'd2, JUNK, 128'h00010203101112130405060714151617},          // R8 word
        '{2'd2, 2'd0, JUNK, 128'h081809190A1A0B1B0C1C0D1D0E1E0F1F},          // R9 byte
        '{2'd2, 2'd1, JUNK, 128'h080918190A0B1A1B0C0D1C1D0E0F1E1F},          // R9 half
        '{2'd2, 2'd2, JUNK, 128'h08090A0B18191A1B0C0D0E0F1C1D1E1F},          // R9 word
        '{2'd3, 2'd1, 128'h0F0E0D0C0B0A09080706050403020100,
                      128'h0F0E0D0C0B0A09080706050403020100},                 // R10 code 3 = none
        '{2'd1, 2'd3, JUNK, 128'h00010203101112130405060714151617}           // R8 size code 3
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, ctrl = '0;
    logic [1:0]   merge_mode = '0, merge_size = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    vperm_unit i_vperm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
        .merge_mode(merge_mode), .merge_size(merge_size),
        .out_valid(out_valid), .result(result)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %032h expected %032h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [127:0] v, input int k);
        return v[127 - 8*k -: 8];
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c, input logic [1:0] m,
                                           input logic [1:0] s);
        logic [127:0] r;
        r = '0;
        if (m == 2'd1 || m == 2'd2) begin
            int eb;
            int n;
            eb = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
            n  = 16 / eb;
            for (int i = 0; i < n/2; i++) begin
                int se;
                se = (m == 2'd2) ? n/2 + i : i;
                for (int o = 0; o < eb; o++) begin
                    r[127 - 8*((2*i)*eb + o) -: 8]   = byte_of(a, se*eb + o);
                    r[127 - 8*((2*i+1)*eb + o) -: 8] = byte_of(b, se*eb + o);
                end
            end
        end else begin
            for (int k = 0; k < 16; k++) begin
                int ix;
                ix = int'(byte_of(c, k) % 8'd32);
                r[127 - 8*k -: 8] = (ix < 16) ? byte_of(a, ix) : byte_of(b, ix - 16);
            end
        end
        return r;
    endfunction

    task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                         input logic [1:0] m, input logic [1:0] s);
        @(negedge clk);
        src_a = a; src_b = b; ctrl = c; merge_mode = m; merge_size = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1;
        // R1: reset state
        chk("R1 out_valid in reset", {127'b0, out_valid}, '0);
        chk("R1 result in reset", result, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {127'b0, out_valid}, '0);
        chk("R1 result after reset", result, '0);

        for (int r = 0; r < NROWS; r++) begin
            string tag;
            issue(SEQ_A, SEQ_B, TBL[r].c, TBL[r].m, TBL[r].s);
            tag = (TBL[r].m == 2'd1) ? "R8 R10" : (TBL[r].m == 2'd2) ? "R9 R10" : "R3 R4 R5 R6";
            chk(tag, result, TBL[r].e);
            chk("R2 out_valid", {127'b0, out_valid}, 128'd1);
        end

        // R2: latency, no result before the capturing edge
        @(negedge clk);
        chk("R2 idle valid", {127'b0, out_valid}, '0);
        src_a = JUNK; src_b = ~JUNK; ctrl = SEQ_B; merge_mode = 2'd0; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        chk("R2 captured", result, ~JUNK);
        chk("R2 valid one cycle", {127'b0, out_valid}, 128'd1);

        // R7: idle cycles with changing inputs leave result unchanged
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            src_a = {4{$urandom}}; src_b = {4{$urandom}}; ctrl = {4{$urandom}};
            merge_mode = 2'(k);
            @(negedge clk);
            chk("R7 hold", result, ~JUNK);
        end

        // R3 R4 R5 R10: random sources and controls against the model
        for (int k = 0; k < 40; k++) begin
            logic [127:0] a, b, c;
            logic [1:0] m, s;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            m = 2'($urandom); s = 2'($urandom);
            issue(a, b, c, m, s);
            chk("R3 R4 R5 R8 R9 R10 random", result, model(a, b, c, m, s));
        end

        // R10: merge result independent of ctrl
        begin
            logic [127:0] a, b, first;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            issue(a, b, '0, 2'd2, 2'd1);
            first = result;
            issue(a, b, '1, 2'd2, 2'd1);
            chk("R10 ctrl ignored in merge", result, first);
        end

        // R1: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule